// File: doc/BRIEF.md
# Shared PWM Tick Source Generator

This block supplies the time base for a bank of PWM channel counters. A free-running power-of-two prescaler, clocked from the master clock, produces eleven single-cycle enable ticks at the master rate divided by 1, 2, 4 and so on up to 1024. Two independent linear dividers each pick one of those prescaler taps and count its ticks down by a programmable ratio of 1 to 255. The eleven taps and the two divider outputs form a set of thirteen tick sources.

Each channel has a 4-bit select code that routes one of the thirteen sources to that channel's tick output. Every output is a clock enable in the master-clock domain, high for one cycle per event. No derived clock leaves the block. Software loads both dividers with a single 32-bit configuration word.

The asynchronous active-low reset is released synchronously inside the block. Tick generation begins a few cycles after reset is released.

Top module: `pwm_tick_gen`

## Requirements
- R1: While rst_n is low every output is 0. Within 4 clock cycles after rst_n rises, src_ticks[0] goes high, and from then on it stays high in every cycle.
- R2: Let n = 0 be the first cycle in which src_ticks[0] is high. Prescaler tap k (src_ticks[k], k = 0..10) is high exactly in the cycles where n mod 2^k equals 2^k-1. Each tap is therefore a single-cycle tick with period 2^k, and any lower tap is also high whenever tap k is high.
- R3: When cfg_we is high at a rising clock edge, cfg_wdata is loaded into the dividers, and the new values govern the following cycle onward. The field positions are: divider A ratio in bits 7:0, divider A tap select in bits 11:8, divider B ratio in bits 23:16, divider B tap select in bits 27:24. All other bits are ignored.
- R4: A divider with ratio R in 1..255 ticks in the same cycle as every R-th tick of its selected tap. Divider A drives src_ticks[11] and divider B drives src_ticks[12]. A ratio of 1 reproduces the tap unchanged.
- R5: A divider whose ratio is 0, or whose tap select is 11 to 15, produces no ticks.
- R6: A configuration write that changes a divider's ratio or tap select restarts that divider's count, so its next tick falls on the R-th tap tick after the write. A write that leaves both fields of a divider unchanged does not disturb that divider's count.
- R7: Channel c's 4-bit code sits in ch_sel[4c+3:4c]. Codes 0 to 12 make ch_tick[c] equal src_ticks[code] in the same cycle.
- R8: Codes 13, 14 and 15 hold ch_tick[c] at 0.
- R9: Reset clears both divider ratios to 0, so src_ticks[12:11] stay 0 until a configuration write arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word for the two dividers |
| ch_sel | input | 4*NUM_CH | Per-channel source select codes, 4 bits each |
| src_ticks | output | 13 | All thirteen tick sources: taps 0..10, divider A, divider B |
| ch_tick | output | NUM_CH | Selected tick enable for each channel |

## Verification
The tap and divider ticks are combinational outputs of registered state. A tick is therefore due in the same cycle as the count it depends on, and a configuration write takes effect in the cycle after the edge that captures it. A select code change reaches ch_tick with no delay. The bench changes inputs just after a rising edge. On every falling edge a reference model advances its own cycle index, tap phases and divider counters, and pushes the expected outputs into a queue. A monitor pops each item a moment later and compares it with the outputs of that same cycle. The model applies a pending write only after it has computed that cycle's expectation, which matches the one-cycle load delay.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int NUM_TAPS   = 11;
  localparam int NUM_DIV    = 2;
  localparam int NUM_SRC    = NUM_TAPS + NUM_DIV;
  localparam int SEL_W      = 4;
  localparam int RATIO_W    = 8;
  localparam int CFG_W      = 32;
  localparam int DIV_STRIDE = 16;
  localparam int RATIO_LSB  = 0;
  localparam int TSEL_LSB   = 8;

  typedef struct packed {
    logic [SEL_W-1:0]   tap_sel;
    logic [RATIO_W-1:0] ratio;
  } div_cfg_t;
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int NTAP = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NTAP-1:0] taps
);
  localparam int CW = NTAP - 1;

  logic          run_q, run_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    run_nxt = 1'b1;
    cnt_nxt = cnt_q;
    if (run_q) cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign taps[0] = run_q;

  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    assign taps[k] = run_q & (&cnt_q[k-1:0]);

    // R2
    tap_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taps[k] |=> !taps[k]);

    // R2
    tap_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taps[k] |-> taps[k-1]);
  end

  // R1
  tap0_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taps[0] |=> taps[0]);
endmodule

// File: rtl/tick_lin_div.sv
module tick_lin_div
  import pwm_tick_pkg::*;
#(
  parameter int NTAP = NUM_TAPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTAP-1:0] taps,
  input  logic            wr_en,
  input  div_cfg_t        wr_cfg,
  output logic            tick
);
  localparam int PADW = (2**SEL_W) - NTAP;

  div_cfg_t            cfg_q, cfg_nxt;
  logic [RATIO_W-1:0]  cnt_q, cnt_nxt;
  logic [2**SEL_W-1:0] taps_ext;
  logic                tap_in;
  logic                active;
  logic                hit;
  logic                changed;

  assign taps_ext = {{PADW{1'b0}}, taps};
  assign tap_in   = taps_ext[cfg_q.tap_sel];
  assign active   = tap_in && (cfg_q.ratio != '0);
  assign hit      = active && (cnt_q == (cfg_q.ratio - RATIO_W'(1)));
  assign changed  = wr_en && (wr_cfg != cfg_q);

  always_comb begin
    cfg_nxt = cfg_q;
    cnt_nxt = cnt_q;
    if (wr_en) cfg_nxt = wr_cfg;
    if (changed)     cnt_nxt = '0;
    else if (hit)    cnt_nxt = '0;
    else if (active) cnt_nxt = cnt_q + RATIO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign tick = hit;

  // R4
  tick_needs_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> tap_in);

  // R4
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg_q.ratio > RATIO_W'(1) && !wr_en) |=> !tick);

  // R3
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(wr_cfg)));

  // R5
  bad_tap_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.tap_sel >= SEL_W'(NTAP)) |-> !tick);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> (cnt_q == '0));
endmodule

// File: rtl/tick_src_mux.sv
module tick_src_mux
  import pwm_tick_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic            tick
);
  localparam int PADW = (2**SEL_W) - NSRC;

  logic [2**SEL_W-1:0] src_ext;

  assign src_ext = {{PADW{1'b0}}, src};
  assign tick    = src_ext[sel];

  // R8
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= SEL_W'(NSRC)) |-> !tick);

  // R7
  tick_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (src != '0));
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tick_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic [NUM_CH*SEL_W-1:0] ch_sel,
  output logic [NUM_SRC-1:0]      src_ticks,
  output logic [NUM_CH-1:0]       ch_tick
);
  logic                rst_n_int;
  logic [NUM_TAPS-1:0] taps;
  logic [NUM_DIV-1:0]  div_ticks;

  tick_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tick_prescaler #(.NTAP(NUM_TAPS)) u_pre (
    .clk   (clk),
    .rst_n (rst_n_int),
    .taps  (taps)
  );

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
    div_cfg_t wcfg;
    assign wcfg.ratio   = cfg_wdata[d*DIV_STRIDE + RATIO_LSB +: RATIO_W];
    assign wcfg.tap_sel = cfg_wdata[d*DIV_STRIDE + TSEL_LSB +: SEL_W];

    tick_lin_div #(.NTAP(NUM_TAPS)) u_div (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .taps   (taps),
      .wr_en  (cfg_we),
      .wr_cfg (wcfg),
      .tick   (div_ticks[d])
    );
  end

  assign src_ticks = {div_ticks, taps};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tick_src_mux #(.NSRC(NUM_SRC)) u_mux (
      .clk   (clk),
      .rst_n (rst_n_int),
      .src   (src_ticks),
      .sel   (ch_sel[c*SEL_W +: SEL_W]),
      .tick  (ch_tick[c])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> (src_ticks == '0));
endmodule

// File: tb/tb_pwm_tick_gen.sv
module tb_pwm_tick_gen;
  localparam int NCH  = 4;
  localparam int NSRC = 13;

  logic            clk;
  logic            rst_n;
  logic            cfg_we;
  logic [31:0]     cfg_wdata;
  logic [NCH*4-1:0] ch_sel;
  logic [NSRC-1:0] src_ticks;
  logic [NCH-1:0]  ch_tick;

  pwm_tick_gen #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ch_sel(ch_sel), .src_ticks(src_ticks), .ch_tick(ch_tick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [NSRC-1:0] src;
    logic [NCH-1:0]  ch;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   errors  = 0;
  logic started = 1'b0;
  int   n = 0;
  int   mr [2];
  int   ms [2];
  int   mc [2];

  // Reference model: computes each cycle's expectation from the requirements
  always @(negedge clk) begin
    exp_t e;
    e = '0;
    if (!rst_n) begin
      started = 1'b0;
      for (int d = 0; d < 2; d++) begin mr[d] = 0; ms[d] = 0; mc[d] = 0; end
    end else begin
      if (!started && src_ticks[0]) begin started = 1'b1; n = 0; end
      if (started) begin
        for (int k = 0; k < 11; k++)
          e.src[k] = (((n + 1) % (1 << k)) == 0);
        for (int d = 0; d < 2; d++) begin
          logic t;
          t = (ms[d] < 11) ? e.src[ms[d]] : 1'b0;
          if (t && mr[d] != 0) begin
            if (mc[d] == mr[d] - 1) begin e.src[11+d] = 1'b1; mc[d] = 0; end
            else mc[d] = mc[d] + 1;
          end
        end
        if (cfg_we) begin
          for (int d = 0; d < 2; d++) begin
            int nr, ns;
            nr = int'(cfg_wdata[d*16 +: 8]);
            ns = int'(cfg_wdata[d*16+8 +: 4]);
            if (nr != mr[d] || ns != ms[d]) mc[d] = 0;
            mr[d] = nr; ms[d] = ns;
          end
        end
        n++;
      end
      for (int c = 0; c < NCH; c++) begin
        int code;
        code = int'(ch_sel[c*4 +: 4]);
        e.ch[c] = (code < 13) ? e.src[code] : 1'b0;
      end
    end
    exp_q.push_back(e);
  end

  // Monitor: pops and compares against the outputs of the same cycle
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      vectors++;
      if (!rst_n && (src_ticks != '0 || ch_tick != '0)) begin
        errors++;
        $display("FAIL R1 R9 reset outputs: src=%h ch=%h expected 0", src_ticks, ch_tick);
      end else begin
        if (src_ticks[10:0] != e.src[10:0]) begin
          errors++;
          $display("FAIL R2 taps n=%0d: got %h expected %h", n, src_ticks[10:0], e.src[10:0]);
        end
        if (src_ticks[12:11] != e.src[12:11]) begin
          errors++;
          $display("FAIL R3 R4 R5 R6 R9 dividers n=%0d: got %b expected %b",
                   n, src_ticks[12:11], e.src[12:11]);
        end
        if (ch_tick != e.ch) begin
          errors++;
          $display("FAIL R7 R8 channels sel=%h: got %b expected %b", ch_sel, ch_tick, e.ch);
        end
      end
    end
  end

  task automatic cycles(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  task automatic write_cfg(input logic [31:0] w);
    cfg_wdata = w;
    cfg_we    = 1'b1;
    cycles(1);
    cfg_we    = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int ra, input int sa, input int rb, input int sb,
                                     input logic [3:0] junk);
    return {junk, 4'(sb), 8'(rb), junk, 4'(sa), 8'(ra)};
  endfunction

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; ch_sel = '0;
    cycles(5);
    rst_n = 1'b1;
    // R1: tap 0 must start within 4 cycles
    begin
      int w;
      w = 0;
      while (!started && w < 6) begin @(negedge clk); #2; w++; end
      vectors++;
      if (!started || w > 4) begin
        errors++;
        $display("FAIL R1 start delay: got %0d cycles expected <= 4", w);
      end
    end
    @(posedge clk); #2;
    // R2, R9: taps run, dividers silent, through a full 1024 wrap
    ch_sel = {4'd10, 4'd12, 4'd11, 4'd0};
    cycles(2100);
    // R3, R4: A = /3 on tap 2, B = /1 on tap 4 (pass-through); junk in unused bits
    write_cfg(mk(3, 2, 1, 4, 4'hF));
    ch_sel = {4'd13, 4'd12, 4'd11, 4'd5};
    cycles(300);
    // R6: change A ratio mid-count, rewrite B unchanged
    cycles(3);
    write_cfg(mk(5, 2, 1, 4, 4'h0));
    cycles(257);
    write_cfg(mk(5, 1, 1, 4, 4'hA));
    cycles(131);
    // R5: A ratio 0, B tap select 12
    write_cfg(mk(0, 1, 7, 12, 4'h0));
    ch_sel = {4'd15, 4'd14, 4'd12, 4'd11};
    cycles(400);
    // R4: large ratio on tap 0, B /2 on tap 10
    write_cfg(mk(255, 0, 2, 10, 4'h5));
    cycles(2200);
    // R7, R8: sweep every code on every channel
    for (int code = 0; code < 16; code++) begin
      ch_sel = {4'(code), 4'(15 - code), 4'(code), 4'((code + 7) % 16)};
      cycles(70);
    end
    // R6: rapid rewrites with changing tap select
    write_cfg(mk(4, 3, 9, 0, 4'h0));
    cycles(5);
    write_cfg(mk(4, 5, 9, 0, 4'h0));
    cycles(600);
    cycles(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule